// File: doc/BRIEF.md
# Zoned Configuration Boot Loader

This block runs once after reset and copies configuration data from a serial EEPROM into the chip's internal registers. It asks a word-read engine for consecutive 16-bit words starting at address 0. It reads a header word first and checks a 12-bit signature in that word. It then decodes four presence flags from the header. The loader walks each present zone in ascending order and turns every data word into a register-write transaction. Each transaction carries a zone code, an index within the zone and the word itself. The data of the present zones is packed back to back behind the header, and an absent zone takes up no words.

While a download is in progress, `busy` is high. The host bus interface uses `busy` to answer every access with a retry. The sequence ends early in two cases: the read engine reports that no EEPROM is fitted, or the header signature is wrong. Software can start a fresh download by pulsing a reload request. The request stays visible as a pending bit until the loader is back in its initial state.

The read-request, read-response and register-write channels all use valid/ready handshakes. A valid signal, once raised, stays high with its payload unchanged until ready is seen in the same cycle. The loader never needs more than one transfer in flight. A stalled ready therefore just stretches the sequence and loses nothing.

Top module: `cfg_boot_loader`

## Requirements
- R1: From reset and from each restart, `busy` is high and the first read request is for address 0. `busy` stays high until the sequence ends, then drops and stays low until a reload.
- R2: A header whose bits 15:4 equal 0x950 sets `prog_valid`. Any other value ends the sequence with no writes and `prog_valid` low.
- R3: If a read response arrives with `rd_rsp_absent` high, the sequence ends with no writes and `prog_valid` low.
- R4: Header bit 3 marks zone 1, bit 2 zone 2, bit 1 zone 3 and bit 0 zone 4 as present. Present zones are visited in ascending order. Their words are read from consecutive addresses that follow the header. `wr_zone` carries code 0 for zone 1, 1 for zone 2, 2 for zone 3 and 3 for zone 4.
- R5: In zones 2 and 4, bit 15 of a word set to 1 means another word of the same zone follows, and 0 ends the zone. The first word of zone 4 is always followed by a second word, whatever its bit 15.
- R6: Zone 1 is taken in pairs. The word at an even index is always followed by another word. The bit 15 of the word at an odd index decides whether a further pair follows.
- R7: Zone 3 ends on a word with bit 15 clear, or after its fourth word (index 3), whichever comes first.
- R8: `wr_index` starts at 0 in every zone and rises by one per word. `wr_data` is the EEPROM word unchanged, bit 15 included.
- R9: A request or write that is waiting for ready keeps its valid signal and payload stable until it is accepted.
- R10: A `reload_set` pulse sets `reload_pend` on the next clock edge. Once the loader is idle, it restarts as if from reset, and `reload_pend` clears when the initial state is entered. A pulse that arrives during a download starts a new download after the current one completes.
- R11: A valid header with all four presence flags clear sets `prog_valid`, produces no writes and ends after the single header read.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| reload_set | input | 1 | One-cycle request to repeat the download |
| reload_pend | output | 1 | Reload requested and not yet started |
| busy | output | 1 | Download in progress; host accesses get a retry |
| prog_valid | output | 1 | A valid header was found in the current download |
| rd_req_valid | output | 1 | Word read request valid |
| rd_req_ready | input | 1 | Read engine accepts the request |
| rd_req_addr | output | ADDR_W | Word address to read |
| rd_rsp_valid | input | 1 | Read response valid |
| rd_rsp_ready | output | 1 | Loader accepts the response |
| rd_rsp_data | input | WORD_W | Word read from the EEPROM |
| rd_rsp_absent | input | 1 | No EEPROM answered; data is meaningless |
| wr_valid | output | 1 | Register write valid |
| wr_ready | input | 1 | Register file accepts the write |
| wr_zone | output | 2 | Target zone code (0..3 for zones 1..4) |
| wr_index | output | IDX_W | Word index within the zone |
| wr_data | output | WORD_W | Word to write |

## Verification
Seven header-and-image patterns are each loaded through a reload. Together they cover:
- all four zones present, where even-index zone-1 continuation and the forced second word of zone 4 show up together;
- zones 1 and 3 only, with a second zone-1 pair and the four-word cap in zone 3 reached while bit 15 is still set;
- zone 2 alone, with a long chain of continuation bits;
- zone 4 alone, where the first word has bit 15 clear;
- two corrupted signatures;
- a valid header that flags no zones.

The write stream and the address list of each run are compared word by word. This separates errors in zone order from errors in length rules and in address packing. Both ready inputs stall on fixed patterns throughout. Directed runs add a fitted-nothing response and a reload that arrives in the middle of a download.

// File: rtl/cfg_boot_pkg.sv
package cfg_boot_pkg;

  localparam int NUM_ZONES = 4;
  localparam int ZONE_W    = 2;
  localparam logic [11:0] HDR_SIG = 12'h950;

  typedef enum logic [ZONE_W-1:0] {
    ZONE_FN  = 2'd0,
    ZONE_LOC = 2'd1,
    ZONE_ID  = 2'd2,
    ZONE_CFG = 2'd3
  } zone_e;

  typedef enum logic [2:0] {
    ST_START,
    ST_REQ,
    ST_WAIT,
    ST_WRITE,
    ST_DONE
  } boot_st_e;

endpackage

// File: rtl/boot_hdr_check.sv
module boot_hdr_check
  import cfg_boot_pkg::*;
#(
  parameter int WORD_W = 16,
  localparam int SIG_W = WORD_W - NUM_ZONES
) (
  input  logic [WORD_W-1:0]    word,
  output logic                 sig_ok,
  output logic [NUM_ZONES-1:0] present
);

  assign sig_ok = (word[WORD_W-1:NUM_ZONES] == SIG_W'(HDR_SIG));

  // Highest flag bit belongs to the lowest-numbered zone.
  for (genvar g = 0; g < NUM_ZONES; g++) begin : g_flag
    assign present[g] = word[NUM_ZONES-1-g];
  end

endmodule

// File: rtl/boot_zone_sel.sv
module boot_zone_sel
  import cfg_boot_pkg::*;
(
  input  logic [NUM_ZONES-1:0] present,
  input  logic [ZONE_W-1:0]    cur,
  input  logic                 from_start,
  output logic                 found,
  output logic [ZONE_W-1:0]    nxt
);

  logic [NUM_ZONES-1:0] cand;

  for (genvar g = 0; g < NUM_ZONES; g++) begin : g_cand
    assign cand[g] = present[g] && (from_start || (ZONE_W'(g) > cur));
  end

  always_comb begin
    found = 1'b0;
    nxt   = '0;
    for (int i = NUM_ZONES - 1; i >= 0; i--) begin
      if (cand[i]) begin
        found = 1'b1;
        nxt   = ZONE_W'(i);
      end
    end
  end

endmodule

// File: rtl/boot_len_rule.sv
module boot_len_rule
  import cfg_boot_pkg::*;
#(
  parameter int IDX_W  = 8,
  parameter int Z3_MAX = 4,
  parameter int Z4_MIN = 2
) (
  input  logic [ZONE_W-1:0] zone,
  input  logic [IDX_W-1:0]  idx,
  input  logic              cont_bit,
  output logic              more
);

  localparam logic [IDX_W-1:0] Z3_LAST = IDX_W'(Z3_MAX - 1);
  localparam logic [IDX_W-1:0] Z4_LAST = IDX_W'(Z4_MIN - 1);

  always_comb begin
    unique case (zone_e'(zone))
      ZONE_FN:  more = ~idx[0] | cont_bit;              // pairs
      ZONE_LOC: more = cont_bit;
      ZONE_ID:  more = (idx < Z3_LAST) && cont_bit;     // capped length
      ZONE_CFG: more = (idx < Z4_LAST) || cont_bit;     // minimum length
      default:  more = 1'b0;
    endcase
  end

endmodule

// File: rtl/cfg_boot_loader.sv
module cfg_boot_loader
  import cfg_boot_pkg::*;
#(
  parameter int ADDR_W = 10,
  parameter int IDX_W  = 8,
  parameter int WORD_W = 16,
  parameter int Z3_MAX = 4,
  parameter int Z4_MIN = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reload_set,
  output logic              reload_pend,
  output logic              busy,
  output logic              prog_valid,
  output logic              rd_req_valid,
  input  logic              rd_req_ready,
  output logic [ADDR_W-1:0] rd_req_addr,
  input  logic              rd_rsp_valid,
  output logic              rd_rsp_ready,
  input  logic [WORD_W-1:0] rd_rsp_data,
  input  logic              rd_rsp_absent,
  output logic              wr_valid,
  input  logic              wr_ready,
  output logic [1:0]        wr_zone,
  output logic [IDX_W-1:0]  wr_index,
  output logic [WORD_W-1:0] wr_data
);

  localparam int CONT_BIT = WORD_W - 1;
  localparam int SIG_W    = WORD_W - NUM_ZONES;

  boot_st_e             state_q;
  logic [ADDR_W-1:0]    addr_q;
  logic [ZONE_W-1:0]    zone_q;
  logic [IDX_W-1:0]     idx_q;
  logic [WORD_W-1:0]    word_q;
  logic [NUM_ZONES-1:0] pres_q;
  logic                 in_hdr_q;
  logic                 valid_q;
  logic                 pend_q;

  logic                 sig_ok;
  logic [NUM_ZONES-1:0] dec_pres;
  logic [NUM_ZONES-1:0] sel_pres;
  logic                 nxt_found;
  logic [ZONE_W-1:0]    nxt_zone;
  logic                 more;
  logic                 rsp_take;
  logic                 wr_take;

  boot_hdr_check #(.WORD_W(WORD_W)) u_hdr (
    .word    (rd_rsp_data),
    .sig_ok  (sig_ok),
    .present (dec_pres)
  );

  assign sel_pres = in_hdr_q ? dec_pres : pres_q;

  boot_zone_sel u_sel (
    .present    (sel_pres),
    .cur        (zone_q),
    .from_start (in_hdr_q),
    .found      (nxt_found),
    .nxt        (nxt_zone)
  );

  boot_len_rule #(.IDX_W(IDX_W), .Z3_MAX(Z3_MAX), .Z4_MIN(Z4_MIN)) u_len (
    .zone     (zone_q),
    .idx      (idx_q),
    .cont_bit (word_q[CONT_BIT]),
    .more     (more)
  );

  assign rsp_take = (state_q == ST_WAIT) && rd_rsp_valid;
  assign wr_take  = (state_q == ST_WRITE) && wr_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q  <= ST_START;
      addr_q   <= '0;
      zone_q   <= '0;
      idx_q    <= '0;
      word_q   <= '0;
      pres_q   <= '0;
      in_hdr_q <= 1'b1;
      valid_q  <= 1'b0;
    end else begin
      unique case (state_q)
        ST_START: begin
          addr_q   <= '0;
          zone_q   <= '0;
          idx_q    <= '0;
          pres_q   <= '0;
          in_hdr_q <= 1'b1;
          valid_q  <= 1'b0;
          state_q  <= ST_REQ;
        end
        ST_REQ: begin
          if (rd_req_ready) state_q <= ST_WAIT;
        end
        ST_WAIT: begin
          if (rsp_take) begin
            if (rd_rsp_absent) begin
              state_q <= ST_DONE;
            end else if (in_hdr_q) begin
              if (sig_ok) begin
                valid_q  <= 1'b1;
                pres_q   <= dec_pres;
                in_hdr_q <= 1'b0;
                if (nxt_found) begin
                  zone_q  <= nxt_zone;
                  idx_q   <= '0;
                  addr_q  <= addr_q + 1'b1;
                  state_q <= ST_REQ;
                end else begin
                  state_q <= ST_DONE;
                end
              end else begin
                state_q <= ST_DONE;
              end
            end else begin
              word_q  <= rd_rsp_data;
              state_q <= ST_WRITE;
            end
          end
        end
        ST_WRITE: begin
          if (wr_ready) begin
            if (more) begin
              idx_q   <= idx_q + 1'b1;
              addr_q  <= addr_q + 1'b1;
              state_q <= ST_REQ;
            end else if (nxt_found) begin
              zone_q  <= nxt_zone;
              idx_q   <= '0;
              addr_q  <= addr_q + 1'b1;
              state_q <= ST_REQ;
            end else begin
              state_q <= ST_DONE;
            end
          end
        end
        ST_DONE: begin
          if (pend_q) state_q <= ST_START;
        end
        default: state_q <= ST_START;
      endcase
    end
  end

  // Reload request: held until the initial state is entered.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                 pend_q <= 1'b0;
    else if (reload_set)        pend_q <= 1'b1;
    else if (state_q == ST_START) pend_q <= 1'b0;
  end

  assign reload_pend  = pend_q;
  assign busy         = (state_q != ST_DONE);
  assign prog_valid   = valid_q;
  assign rd_req_valid = (state_q == ST_REQ);
  assign rd_req_addr  = addr_q;
  assign rd_rsp_ready = (state_q == ST_WAIT);
  assign wr_valid     = (state_q == ST_WRITE);
  assign wr_zone      = zone_q;
  assign wr_index     = idx_q;
  assign wr_data      = word_q;

  assert_req_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    rd_req_valid && !rd_req_ready |=> rd_req_valid && $stable(rd_req_addr));

  assert_wr_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    wr_valid && !wr_ready |=> wr_valid && $stable(wr_data) && $stable(wr_zone) && $stable(wr_index));

  assert_write_needs_sig_R2: assert property (@(posedge clk) disable iff (!rst_n)
    wr_valid |-> prog_valid);

  assert_bad_sig_stops_R2: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_take && in_hdr_q && !rd_rsp_absent && (rd_rsp_data[WORD_W-1:NUM_ZONES] != SIG_W'(HDR_SIG))
    |=> !busy && !prog_valid);

  assert_absent_stops_R3: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_take && rd_rsp_absent |=> !busy && !prog_valid);

  assert_fn_pairs_R6: assert property (@(posedge clk) disable iff (!rst_n)
    wr_take && (zone_q == ZONE_FN) && !more |-> idx_q[0]);

  assert_id_cap_R7: assert property (@(posedge clk) disable iff (!rst_n)
    wr_valid && (wr_zone == ZONE_ID) |-> wr_index < IDX_W'(Z3_MAX));

  assert_reload_latch_R10: assert property (@(posedge clk) disable iff (!rst_n)
    reload_set |=> reload_pend);

endmodule

// File: tb/cfg_boot_loader_tb_top.sv
`timescale 1ns/1ps
module cfg_boot_loader_tb_top;

  localparam int ADDR_W = 10;
  localparam int IDX_W  = 8;
  localparam int NVEC   = 7;
  localparam int IMG_N  = 9;
  localparam int CAP_N  = 32;

  // Images: word 0 is the header; unused tail words are filler.
  localparam logic [15:0] VEC [NVEC][IMG_N] = '{
    '{16'h950F, 16'h0001, 16'h0002, 16'h0003, 16'h8004, 16'h0005, 16'h0006, 16'h0007, 16'hDEAD},
    '{16'h950A, 16'h0011, 16'h8012, 16'h0013, 16'h0014, 16'h8021, 16'h8022, 16'h8023, 16'h8024},
    '{16'h9504, 16'h8100, 16'h8101, 16'h8102, 16'h0103, 16'hDEAD, 16'hDEAD, 16'hDEAD, 16'hDEAD},
    '{16'h9501, 16'h0200, 16'h8201, 16'h0202, 16'hDEAD, 16'hDEAD, 16'hDEAD, 16'hDEAD, 16'hDEAD},
    '{16'h9510, 16'h0001, 16'h0002, 16'h0003, 16'h0004, 16'h0005, 16'h0006, 16'h0007, 16'h0008},
    '{16'h9500, 16'h0001, 16'h0002, 16'h0003, 16'h0004, 16'h0005, 16'h0006, 16'h0007, 16'h0008},
    '{16'h1950, 16'h0001, 16'h0002, 16'h0003, 16'h0004, 16'h0005, 16'h0006, 16'h0007, 16'h0008}
  };
  localparam int EXP_WR [NVEC] = '{7, 8, 4, 3, 0, 0, 0};
  localparam bit EXP_OK [NVEC] = '{1'b1, 1'b1, 1'b1, 1'b1, 1'b0, 1'b1, 1'b0};

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic reload_set = 1'b0;
  logic reload_pend, busy, prog_valid;
  logic rd_req_valid, rd_req_ready = 1'b0;
  logic [ADDR_W-1:0] rd_req_addr;
  logic rd_rsp_valid = 1'b0, rd_rsp_ready;
  logic [15:0] rd_rsp_data = '0;
  logic rd_rsp_absent = 1'b0;
  logic wr_valid, wr_ready = 1'b0;
  logic [1:0] wr_zone;
  logic [IDX_W-1:0] wr_index;
  logic [15:0] wr_data;

  always #4 clk = ~clk;

  cfg_boot_loader #(.ADDR_W(ADDR_W), .IDX_W(IDX_W)) dut_i (
    .clk(clk), .rst_n(rst_n), .reload_set(reload_set), .reload_pend(reload_pend),
    .busy(busy), .prog_valid(prog_valid),
    .rd_req_valid(rd_req_valid), .rd_req_ready(rd_req_ready), .rd_req_addr(rd_req_addr),
    .rd_rsp_valid(rd_rsp_valid), .rd_rsp_ready(rd_rsp_ready), .rd_rsp_data(rd_rsp_data),
    .rd_rsp_absent(rd_rsp_absent),
    .wr_valid(wr_valid), .wr_ready(wr_ready), .wr_zone(wr_zone), .wr_index(wr_index),
    .wr_data(wr_data)
  );

  int n_chk = 0;
  int n_fail = 0;
  int cur_vec = 0;
  bit absent_mode = 1'b0;
  int n_rd = 0;
  int n_wr = 0;
  int cap_addr [CAP_N];
  int cap_zone [CAP_N];
  int cap_idx  [CAP_N];
  int cap_data [CAP_N];
  int exp_zone [CAP_N];
  int exp_idx  [CAP_N];
  int exp_data [CAP_N];
  int exp_rd;

  task automatic chk_eq(string req, string what, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  function automatic logic [15:0] mem_word(int v, int a);
    return (a < IMG_N) ? VEC[v][a] : 16'hFFFF;
  endfunction

  // Reference model built from the zone and length requirements.
  function automatic int build_expect(int v);
    int n = 0;
    int a = 1;
    logic [15:0] h = VEC[v][0];
    exp_rd = 1;
    if (h[15:4] != 12'h950) return 0;
    for (int z = 0; z < 4; z++) begin
      if (h[3-z]) begin
        int i = 0;
        bit cont = 1'b1;
        while (cont) begin
          logic [15:0] w = mem_word(v, a);
          exp_zone[n] = z; exp_idx[n] = i; exp_data[n] = int'(w);
          n++; a++; exp_rd++;
          case (z)
            0: cont = (i % 2 == 0) || w[15];
            1: cont = w[15];
            2: cont = (i < 3) && w[15];
            default: cont = (i == 0) || w[15];
          endcase
          i++;
        end
      end
    end
    return n;
  endfunction

  // Memory responder and write sink, stepped at the falling edge.
  initial begin
    int cyc = 0;
    bit req_hs = 1'b0;
    bit rsp_hs = 1'b0;
    int addr_cap = 0;
    forever begin
      @(negedge clk);
      cyc++;
      if (rsp_hs) rd_rsp_valid = 1'b0;
      if (req_hs) begin
        rd_rsp_valid  = 1'b1;
        rd_rsp_absent = absent_mode;
        rd_rsp_data   = absent_mode ? 16'h0000 : mem_word(cur_vec, addr_cap);
      end
      rd_req_ready = (cyc % 2 == 0);
      wr_ready     = (cyc % 3 != 0);
      #1;
      req_hs = rst_n && rd_req_valid && rd_req_ready;
      rsp_hs = rst_n && rd_rsp_valid && rd_rsp_ready;
      if (req_hs) begin
        addr_cap = int'(rd_req_addr);
        if (n_rd < CAP_N) cap_addr[n_rd] = addr_cap;
        n_rd++;
      end
      if (rst_n && wr_valid && wr_ready) begin
        if (n_wr < CAP_N) begin
          cap_zone[n_wr] = int'(wr_zone);
          cap_idx[n_wr]  = int'(wr_index);
          cap_data[n_wr] = int'(wr_data);
        end
        n_wr++;
      end
    end
  end

  task automatic wait_busy(bit level);
    int t = 0;
    while (busy !== level && t < 2000) begin
      @(negedge clk); #2; t++;
    end
    chk_eq("R1", "busy reaches level", int'(busy), int'(level));
  endtask

  task automatic pulse_reload();
    @(negedge clk); #3;
    reload_set = 1'b1;
    @(negedge clk); #3;
    reload_set = 1'b0;
  endtask

  task automatic check_run(int v);
    int ne = build_expect(v);
    chk_eq("R2", $sformatf("vec%0d write count table", v), n_wr, EXP_WR[v]);
    chk_eq("R4", $sformatf("vec%0d write count model", v), n_wr, ne);
    chk_eq("R2", $sformatf("vec%0d prog_valid", v), int'(prog_valid), int'(EXP_OK[v]));
    chk_eq("R4", $sformatf("vec%0d read count", v), n_rd, exp_rd);
    for (int k = 0; k < n_rd && k < CAP_N; k++)
      chk_eq("R4", $sformatf("vec%0d read addr %0d", v, k), cap_addr[k], k);
    for (int k = 0; k < ne && k < n_wr; k++) begin
      chk_eq("R4", $sformatf("vec%0d wr%0d zone", v, k), cap_zone[k], exp_zone[k]);
      chk_eq("R8", $sformatf("vec%0d wr%0d index", v, k), cap_idx[k], exp_idx[k]);
      chk_eq("R8", $sformatf("vec%0d wr%0d data", v, k), cap_data[k], exp_data[k]);
    end
    chk_eq("R10", $sformatf("vec%0d reload_pend cleared", v), int'(reload_pend), 0);
  endtask

  initial begin
    cur_vec = 0;
    absent_mode = 1'b1;
    // R1: reset state
    repeat (3) @(negedge clk);
    #2;
    chk_eq("R1", "busy in reset", int'(busy), 1);
    chk_eq("R1", "prog_valid in reset", int'(prog_valid), 0);
    chk_eq("R1", "wr_valid in reset", int'(wr_valid), 0);
    chk_eq("R1", "rd_req_valid in reset", int'(rd_req_valid), 0);
    rst_n = 1'b1;

    // R3: nothing fitted
    wait_busy(1'b0);
    chk_eq("R3", "absent read count", n_rd, 1);
    chk_eq("R1", "absent first address", cap_addr[0], 0);
    chk_eq("R3", "absent writes", n_wr, 0);
    chk_eq("R3", "absent prog_valid", int'(prog_valid), 0);
    repeat (5) @(negedge clk);
    #2;
    chk_eq("R1", "busy stays low when idle", int'(busy), 0);
    absent_mode = 1'b0;

    // Table walk (R2 R4 R5 R6 R7 R8 R11), each run started by reload (R10)
    for (int v = 0; v < NVEC; v++) begin
      cur_vec = v;
      n_rd = 0; n_wr = 0;
      pulse_reload();
      #2;
      if (v == 0) chk_eq("R10", "reload_pend after pulse", int'(reload_pend), 1);
      wait_busy(1'b1);
      wait_busy(1'b0);
      check_run(v);
    end

    // R11: empty-zone header already in table (vec5); check it read once only
    cur_vec = 5;
    n_rd = 0; n_wr = 0;
    pulse_reload();
    wait_busy(1'b1);
    wait_busy(1'b0);
    chk_eq("R11", "empty header single read", n_rd, 1);
    chk_eq("R11", "empty header prog_valid", int'(prog_valid), 1);

    // R10: reload during a download queues a second full run
    cur_vec = 2;
    n_rd = 0; n_wr = 0;
    pulse_reload();
    wait_busy(1'b1);
    repeat (3) @(negedge clk);
    pulse_reload();
    #2;
    chk_eq("R10", "pend held while busy", int'(reload_pend), 1);
    chk_eq("R10", "still busy", int'(busy), 1);
    begin
      int t = 0;
      while (!(n_rd >= 10 && busy === 1'b0) && t < 4000) begin
        @(negedge clk); #2; t++;
      end
    end
    chk_eq("R10", "two runs read count", n_rd, 10);
    chk_eq("R10", "two runs write count", n_wr, 8);
    for (int k = 0; k < 4; k++)
      chk_eq("R10", $sformatf("rerun data %0d", k), cap_data[k + 4], cap_data[k]);
    chk_eq("R10", "rerun restarts at address 0", cap_addr[5], 0);
    chk_eq("R10", "pend cleared after rerun", int'(reload_pend), 0);

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

endmodule